// File: doc/BRIEF.md
# Neutral Current Mismatch Detector

This block checks that the neutral current of a three-phase system matches the sum of the three phase currents. On every sample strobe it adds the three signed phase samples into a 28-bit signed sum and stores it. It then forms the absolute value of the difference between the magnitude of that sum and the magnitude of the neutral sample. If that value exceeds a programmable threshold, a sticky tamper flag is raised.

The flag can pull an active-low interrupt line when a mask bit enables it. The stored sum is readable together with a sticky data-ready bit. A small register port gives read access to status, mask, threshold and sum. Status bits are cleared by writing one to them. The threshold uses the same scale as the samples, with full scale at 0x5A7540. A threshold of zero or below makes every sample count as a mismatch.

Top module: `ncm_detector`

## Requirements
- R1: On a clock edge where `smp_vld` is high, the sum register takes `ph_a + ph_b + ph_c` as a 28-bit signed value. It reads at address 3 as `{4'b0, sum[27:0]}`, with bit 27 as the sign and no extension above it.
- R2: While `smp_vld` is low, the sum register and both status flags keep their values.
- R3: With a positive threshold T, a sample sets the mismatch flag (bit 20 of the status word at address 0) when `| |sum| - |neu| |` is greater than T. When it is less than or equal to T, the flag is left unchanged.
- R4: When the threshold is zero or negative, every sample sets the mismatch flag, whatever the currents are.
- R5: The mismatch flag stays set until a write to address 0 with data bit 20 at one clears it. A write to address 0 with bit 20 at zero leaves the flag unchanged.
- R6: If a sample sets the mismatch flag in the same cycle that a write clears it, the flag ends up set.
- R7: `irq_n` is low exactly while the mismatch flag and the enable bit (bit 20 of the mask word at address 1, read back at bit 20) are both one.
- R8: Every sample sets the data-ready flag, bit 17 of the word at address 4. A write to address 4 with bit 17 at one clears it. A sample in the same cycle wins over the clear.
- R9: A write to address 2 loads the 24-bit threshold from `wr_data[23:0]`. It reads back sign-extended to 28 bits, with the upper 4 bits zero. Addresses 5 to 7 read as zero.
- R10: After reset, every register reads zero and `irq_n` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_vld | input | 1 | Sample strobe, one cycle per sample set |
| ph_a | input | 24 | Phase A current sample, signed |
| ph_b | input | 24 | Phase B current sample, signed |
| ph_c | input | 24 | Phase C current sample, signed |
| neu | input | 24 | Neutral current sample, signed |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 24 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| irq_n | output | 1 | Active-low mismatch interrupt |

## Verification
A wrong sum shows up at address 3 one edge after the sample that produced it. It also spreads into the mismatch decision for that same sample, so a bad compare flips bit 20 and `irq_n` in that cycle. Because the flags are sticky, one wrong decision stays visible at the ports until software clears it. A reference model checked against the ports on every cycle therefore catches it at once. The tests include edge cases where the difference equals the threshold, where the threshold is zero or negative, and where a set and a clear collide. These cases expose off-by-one and priority errors within a single sample.

// File: rtl/ncm_pkg.sv
package ncm_pkg;
  localparam int ADDR_W = 3;
  typedef enum logic [ADDR_W-1:0] {
    A_STATUS = 3'd0,
    A_ENABLE = 3'd1,
    A_LEVEL  = 3'd2,
    A_SUM    = 3'd3,
    A_READY  = 3'd4
  } reg_addr_e;
  localparam int TAMPER_BIT = 20;
  localparam int READY_BIT  = 17;
endpackage

// File: rtl/ncm_sum_unit.sv
module ncm_sum_unit #(
  parameter int SAMPLE_W = 24,
  parameter int SUM_W    = 28,
  localparam int GW      = SUM_W + 2
) (
  input  logic [SAMPLE_W-1:0] a,
  input  logic [SAMPLE_W-1:0] b,
  input  logic [SAMPLE_W-1:0] c,
  input  logic [SAMPLE_W-1:0] n,
  output logic [SUM_W-1:0]    sum,
  output logic [GW-1:0]       gap
);
  logic signed [GW-1:0] a_x, b_x, c_x, n_x, s_x;
  logic signed [GW-1:0] s_mag, n_mag, d_x;

  always_comb begin
    a_x   = {{(GW-SAMPLE_W){a[SAMPLE_W-1]}}, a};
    b_x   = {{(GW-SAMPLE_W){b[SAMPLE_W-1]}}, b};
    c_x   = {{(GW-SAMPLE_W){c[SAMPLE_W-1]}}, c};
    n_x   = {{(GW-SAMPLE_W){n[SAMPLE_W-1]}}, n};
    s_x   = a_x + b_x + c_x;
    s_mag = s_x[GW-1] ? -s_x : s_x;
    n_mag = n_x[GW-1] ? -n_x : n_x;
    d_x   = s_mag - n_mag;
    gap   = d_x[GW-1] ? -d_x : d_x;
    sum   = s_x[SUM_W-1:0];
  end
endmodule

// File: rtl/ncm_level_cmp.sv
module ncm_level_cmp #(
  parameter int SUM_W = 28,
  localparam int GW   = SUM_W + 2
) (
  input  logic [SUM_W-1:0] level,
  input  logic [GW-1:0]    gap,
  output logic             hit
);
  logic level_nonpos;
  always_comb begin
    level_nonpos = level[SUM_W-1] || (level == '0);
    hit = level_nonpos || (gap > {2'b00, level});
  end
endmodule

// File: rtl/ncm_sticky.sv
module ncm_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);
  logic q_nx;
  always_comb q_nx = set | (q & ~clr);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= q_nx;
  end
endmodule

// File: rtl/ncm_detector.sv
module ncm_detector
  import ncm_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int SUM_W    = 28,
  parameter int RDATA_W  = 32,
  localparam int GW      = SUM_W + 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                smp_vld,
  input  logic [SAMPLE_W-1:0] ph_a,
  input  logic [SAMPLE_W-1:0] ph_b,
  input  logic [SAMPLE_W-1:0] ph_c,
  input  logic [SAMPLE_W-1:0] neu,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [SAMPLE_W-1:0] wr_data,
  input  logic [ADDR_W-1:0]   rd_addr,
  output logic [RDATA_W-1:0]  rd_data,
  output logic                irq_n
);
  logic [SUM_W-1:0]    sum_c, sum_q, sum_nx;
  logic [GW-1:0]       gap_c;
  logic [SAMPLE_W-1:0] lvl_q, lvl_nx;
  logic [SUM_W-1:0]    lvl_ext;
  logic                en_q, en_nx;
  logic                mis_hit, mis_set, mis_clr, mis_flag;
  logic                rdy_set, rdy_clr, rdy_flag;
  logic                wr_stat, wr_en_reg, wr_lvl, wr_rdy;

  ncm_sum_unit #(.SAMPLE_W(SAMPLE_W), .SUM_W(SUM_W)) u_sum (
    .a(ph_a), .b(ph_b), .c(ph_c), .n(neu), .sum(sum_c), .gap(gap_c)
  );

  always_comb lvl_ext = {{(SUM_W-SAMPLE_W){lvl_q[SAMPLE_W-1]}}, lvl_q};

  ncm_level_cmp #(.SUM_W(SUM_W)) u_cmp (
    .level(lvl_ext), .gap(gap_c), .hit(mis_hit)
  );

  always_comb begin
    wr_stat   = wr_en && (wr_addr == A_STATUS);
    wr_en_reg = wr_en && (wr_addr == A_ENABLE);
    wr_lvl    = wr_en && (wr_addr == A_LEVEL);
    wr_rdy    = wr_en && (wr_addr == A_READY);
    mis_set   = smp_vld && mis_hit;
    mis_clr   = wr_stat && wr_data[TAMPER_BIT];
    rdy_set   = smp_vld;
    rdy_clr   = wr_rdy && wr_data[READY_BIT];
    sum_nx    = smp_vld   ? sum_c   : sum_q;
    lvl_nx    = wr_lvl    ? wr_data : lvl_q;
    en_nx     = wr_en_reg ? wr_data[TAMPER_BIT] : en_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q <= '0;
      lvl_q <= '0;
      en_q  <= 1'b0;
    end else begin
      sum_q <= sum_nx;
      lvl_q <= lvl_nx;
      en_q  <= en_nx;
    end
  end

  ncm_sticky u_mis (.clk(clk), .rst_n(rst_n), .set(mis_set), .clr(mis_clr), .q(mis_flag));
  ncm_sticky u_rdy (.clk(clk), .rst_n(rst_n), .set(rdy_set), .clr(rdy_clr), .q(rdy_flag));

  always_comb begin
    rd_data = '0;
    unique case (rd_addr)
      A_STATUS: rd_data[TAMPER_BIT] = mis_flag;
      A_ENABLE: rd_data[TAMPER_BIT] = en_q;
      A_LEVEL:  rd_data[SUM_W-1:0]  = lvl_ext;
      A_SUM:    rd_data[SUM_W-1:0]  = sum_q;
      A_READY:  rd_data[READY_BIT]  = rdy_flag;
      default:  rd_data = '0;
    endcase
    irq_n = ~(mis_flag & en_q);
  end
endmodule

// File: rtl/ncm_detector_chk.sv
module ncm_detector_chk #(
  parameter int SAMPLE_W = 24,
  parameter int SUM_W    = 28
) (
  input logic                clk,
  input logic                rst_n,
  input logic                smp_vld,
  input logic [SAMPLE_W-1:0] ph_a,
  input logic [SAMPLE_W-1:0] ph_b,
  input logic [SAMPLE_W-1:0] ph_c,
  input logic [SUM_W-1:0]    sum_q,
  input logic [SAMPLE_W-1:0] lvl_q,
  input logic                mis_hit,
  input logic                mis_clr,
  input logic                mis_flag,
  input logic                en_q,
  input logic                irq_n
);
  logic [SUM_W-1:0] ref_sum;
  always_comb ref_sum = SUM_W'($signed(ph_a)) + SUM_W'($signed(ph_b)) + SUM_W'($signed(ph_c));

  assert_sum_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
    smp_vld |=> sum_q == $past(ref_sum));
  assert_sum_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_vld |=> $stable(sum_q));
  assert_nonpos_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_vld && ($signed(lvl_q) <= 0)) |=> mis_flag);
  assert_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mis_flag && !mis_clr) |=> mis_flag);
  assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_vld && mis_hit && mis_clr) |=> mis_flag);
  assert_irq_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> (mis_flag && en_q));
endmodule

bind ncm_detector ncm_detector_chk #(.SAMPLE_W(SAMPLE_W), .SUM_W(SUM_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .ph_a(ph_a), .ph_b(ph_b),
  .ph_c(ph_c), .sum_q(sum_q), .lvl_q(lvl_q), .mis_hit(mis_hit),
  .mis_clr(mis_clr), .mis_flag(mis_flag), .en_q(en_q), .irq_n(irq_n)
);

// File: tb/tb_ncm_detector.sv
`timescale 1ns/100ps
module tb_ncm_detector;
  logic        clk, rst_n, smp_vld, wr_en;
  logic [23:0] ph_a, ph_b, ph_c, neu, wr_data;
  logic [2:0]  wr_addr, rd_addr;
  logic [31:0] rd_data;
  logic        irq_n;

  int errors = 0, checks = 0;
  bit done = 0;
  string cur_req = "R10";

  // behavioural model state
  int m_sum = 0, m_lvl = 0;
  bit m_mis = 0, m_rdy = 0, m_en = 0;

  ncm_detector dut (.*);

  initial clk = 0;
  always #2 clk = ~clk;

  function automatic int sx24(input logic [23:0] v);
    return int'($signed(v));
  endfunction
  function automatic int iabs(input int v);
    return (v < 0) ? -v : v;
  endfunction

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", cur_req, what, act, exp);
    end
  endtask

  task automatic check_all();
    logic [31:0] e;
    for (int a = 0; a < 6; a++) begin
      rd_addr = 3'(a);
      #0.2;
      case (a)
        0: e = 32'(m_mis) << 20;
        1: e = 32'(m_en) << 20;
        2: e = 32'(m_lvl) & 32'h0FFF_FFFF;
        3: e = 32'(m_sum) & 32'h0FFF_FFFF;
        4: e = 32'(m_rdy) << 17;
        default: e = 32'h0;
      endcase
      chk($sformatf("reg%0d", a), rd_data, e);
    end
    chk("irq_n", {31'd0, irq_n}, {31'd0, !(m_mis && m_en)});
  endtask

  // one clock: model updates from the inputs present at the edge, then ports are checked
  task automatic step();
    int s, d;
    bit hit, clr_m, clr_r;
    @(posedge clk);
    s = sx24(ph_a) + sx24(ph_b) + sx24(ph_c);
    d = iabs(iabs(s) - iabs(sx24(neu)));
    hit   = (m_lvl <= 0) || (d > m_lvl);
    clr_m = wr_en && wr_addr == 0 && wr_data[20];
    clr_r = wr_en && wr_addr == 4 && wr_data[17];
    m_mis = (smp_vld && hit) || (m_mis && !clr_m);
    m_rdy = smp_vld || (m_rdy && !clr_r);
    if (smp_vld) m_sum = s;
    if (wr_en && wr_addr == 2) m_lvl = sx24(wr_data);
    if (wr_en && wr_addr == 1) m_en = wr_data[20];
    #1;
    check_all();
    smp_vld = 0; wr_en = 0;
  endtask

  task automatic sample(input int a, input int b, input int c, input int n);
    ph_a = 24'(a); ph_b = 24'(b); ph_c = 24'(c); neu = 24'(n); smp_vld = 1;
    step();
  endtask

  task automatic wr(input int addr, input logic [23:0] data);
    wr_addr = 3'(addr); wr_data = data; wr_en = 1;
    step();
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 0; smp_vld = 0; wr_en = 0; wr_addr = 0; wr_data = 0; rd_addr = 0;
    ph_a = 0; ph_b = 0; ph_c = 0; neu = 0;
    #5;
    cur_req = "R10"; check_all();
    @(negedge clk); rst_n = 1;

    cur_req = "R9";  wr(2, 24'd1000); wr(2, 24'hFFFFF0); wr(2, 24'h5A7540);
    wr(2, 24'd1000);
    cur_req = "R7";  wr(1, 24'h100000);
    cur_req = "R3";  sample(100, 200, 300, 600);       // gap 0
    sample(1000, 500, 0, 500);                          // gap exactly 1000: no set
    sample(-1000, -500, -1, 500);                       // gap 1001: set
    cur_req = "R2";  step(); step();
    cur_req = "R5";  wr(0, 24'h0FFFFF); wr(0, 24'h100000);
    sample(10, 10, 10, -30);                            // |30|-|30| = 0
    cur_req = "R6";  ph_a = 24'd5000; ph_b = 0; ph_c = 0; neu = 0; smp_vld = 1;
    wr_addr = 0; wr_data = 24'h100000; wr_en = 1; step();
    cur_req = "R7";  wr(1, 24'h0); wr(1, 24'h100000); wr(0, 24'h100000);
    cur_req = "R4";  wr(2, 24'h0); sample(7, 7, 7, 21);
    wr(0, 24'h100000); wr(2, 24'h800000); sample(0, 0, 0, 0);
    cur_req = "R8";  wr(4, 24'h020000); wr(4, 24'h000000);
    ph_a = 1; ph_b = 1; ph_c = 1; neu = 3; smp_vld = 1;
    wr_addr = 4; wr_data = 24'h020000; wr_en = 1; step();
    cur_req = "R1";  wr(2, 24'h5A7540);
    sample(-8388608, -8388608, -8388608, 0);
    sample(8388607, 8388607, 8388607, -8388608);
    sample(-3, 1, 1, 1);
    for (int i = 0; i < 300; i++) begin
      int a, b, c, n;
      cur_req = "R3";
      if (i % 25 == 0) wr(2, 24'($urandom_range(0, 4000)));
      if (i % 17 == 0) wr(0, 24'h100000);
      a = int'($urandom_range(0, 4000000)) - 2000000;
      b = int'($urandom_range(0, 4000000)) - 2000000;
      c = int'($urandom_range(0, 4000000)) - 2000000;
      n = ((i % 2) ? -(a + b + c) : (a + b + c)) + int'($urandom_range(0, 8000)) - 4000;
      if (i % 3 == 0) step(); else sample(a, b, c, n);
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule